// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is a register-programmed engine that plays out the command and address part of a raw NAND flash operation on an 8-bit bus. Software first loads the address bytes into a low/high register pair, an auxiliary command byte into a separate register, and the strobe timing. It then writes a single command word. Individual bits of that word enable four phases: a first command byte, a run of one to five address cycles, a second command byte, and a wait for the ready/busy line. The engine runs the enabled phases in that fixed order and raises a sticky completion flag at the end.

Command bytes go out with CLE high, and address bytes go out with ALE high. Each byte is marked by a write-enable low pulse followed by a high recovery period. The length of each, in clocks, comes from the timing register. Chip enable is low for the whole sequence. The ready/busy input passes through a two-stage synchronizer. The wait phase begins only after a fixed settle delay, which gives the device time to pull busy low. Page data transfer, error correction, scrambling and DMA are handled elsewhere.

Register map (word offsets on `reg_addr`):

| Offset | Register | Contents |
|---|---|---|
| 0 | control | bit 0 enable, bit 1 soft reset |
| 1 | status | bit 0 busy, bit 1 done |
| 2 | timing | bits 3:0 WE# low clocks, bits 7:4 WE# high clocks |
| 3 | address low | 32 bits |
| 4 | address high | bits 7:0 |
| 5 | auxiliary command | 32 bits, second command byte in bits 7:0 |
| 6 | command word | write only, reads 0 |

Top module: `nand_cmd_seq`

## Requirements
- R1: Command word bit 22 issues the first command byte, taken from command word bits 7:0, with `nand_cle`=1 and `nand_ale`=0 while it is strobed.
- R2: Command word bit 19 issues the address cycles with `nand_ale`=1 and `nand_cle`=0. The number of cycles is the value of bits 18:16 plus one; values of 4 and above give five cycles. Bytes go out least significant first: four bytes from the address low register (offset 3), then bits 7:0 of the address high register (offset 4).
- R3: Command word bit 24 issues a second command byte with `nand_cle`=1. The byte is bits 7:0 of the auxiliary command register (offset 5); the other bits of that register are not sent.
- R4: Enabled phases run in the order first command, address, second command. Each byte holds `nand_we_n` low for the number of clocks in timing bits 3:0, then high for the number in bits 7:4; a field value of 0 counts as 1. With no wait phase, done is visible N*(low+high) clocks after the clock edge that accepts the command word, where N is the number of bytes.
- R5: Command word bit 23 adds a wait phase. It starts 4 clocks after the last strobe ends, and completes on the third clock edge after `nand_rb_n` goes high. While `nand_rb_n` stays low the sequence does not complete.
- R6: Status bit 1 (done) is sticky. Writing a status word with bit 1 set clears it; writing 0 leaves it unchanged.
- R7: Status bit 0 (busy) reads 1 and `nand_ce_n` stays low from the accepting edge until the sequence completes, including the wait phase.
- R8: A command word written while a sequence is running, or while control bit 0 (enable) is 0, is ignored: no strobe, no busy and no done results.
- R9: A command word with bits 19, 22, 23 and 24 all clear sets done on the accepting clock edge and drives no strobe.
- R10: Writing control bit 1 aborts any sequence and returns the engine to idle without setting done. The bit reads 1 in the cycle after the write and 0 from the next cycle on.
- R11: Command word bits 31:30 (command type) do not change which phases run or how long they take.
- R12: After reset, `nand_we_n`=1, `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| nand_io | output | 8 | Command/address byte driven to the flash |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_rb_n | input | 1 | Ready/busy from the flash, asynchronous, low while busy |

## Verification
The assertions assume three things about the inputs. Register writes are single-cycle pulses on a synchronous bus. `nand_rb_n` may change at any time, because it is only seen through the synchronizer. Software writes the status register only to clear done. The `$stable` check on the bus during the low pulse relies on no soft reset arriving in the middle of a strobe. The bench therefore aborts only while the engine sits in the wait phase. It also changes `nand_rb_n` and all bus inputs on the falling clock edge, so every input stays inside these assumptions.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // Command word bit positions (decoded by the sequencer)
  localparam int CW_ADDR_BIT = 19;
  localparam int CW_C1_BIT   = 22;
  localparam int CW_WAIT_BIT = 23;
  localparam int CW_C2_BIT   = 24;

  // Register word offsets
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_TIME = 3'd2;
  localparam logic [2:0] RA_ALO  = 3'd3;
  localparam logic [2:0] RA_AHI  = 3'd4;
  localparam logic [2:0] RA_AUX  = 3'd5;
  localparam logic [2:0] RA_CMDW = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CMD1   = 3'd1,
    S_ADDR   = 3'd2,
    S_CMD2   = 3'd3,
    S_SETTLE = 3'd4,
    S_WAIT   = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic c1;
    logic ad;
    logic c2;
    logic wt;
  } phase_req_t;

  // Next enabled phase after the current one, or idle when none is left
  function automatic seq_state_t phase_after(seq_state_t cur, phase_req_t r);
    if (cur == S_IDLE && r.c1) return S_CMD1;
    if ((cur == S_IDLE || cur == S_CMD1) && r.ad) return S_ADDR;
    if ((cur == S_IDLE || cur == S_CMD1 || cur == S_ADDR) && r.c2) return S_CMD2;
    if (cur != S_SETTLE && cur != S_WAIT && r.wt) return S_SETTLE;
    return S_IDLE;
  endfunction

  // Address cycle count from the minus-one field, capped at five
  function automatic logic [2:0] addr_cycles(logic [2:0] field);
    return (field >= 3'd4) ? 3'd5 : field + 3'd1;
  endfunction

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int AW = 3,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          seq_done,
  output logic          en,
  output logic          soft_rst,
  output logic          cmd_wr,
  output logic          stat_clr,
  output logic          done,
  output logic [TW-1:0] t_lo,
  output logic [TW-1:0] t_hi,
  output logic [39:0]   addr40,
  output logic [7:0]    aux_byte
);
  logic [31:0] addr_lo;
  logic [7:0]  addr_hi;
  logic [31:0] aux_cmd;

  logic wr_ctrl, wr_stat, wr_time, wr_alo, wr_ahi, wr_aux;
  assign wr_ctrl  = reg_wr && (reg_addr == AW'(RA_CTRL));
  assign wr_stat  = reg_wr && (reg_addr == AW'(RA_STAT));
  assign wr_time  = reg_wr && (reg_addr == AW'(RA_TIME));
  assign wr_alo   = reg_wr && (reg_addr == AW'(RA_ALO));
  assign wr_ahi   = reg_wr && (reg_addr == AW'(RA_AHI));
  assign wr_aux   = reg_wr && (reg_addr == AW'(RA_AUX));
  assign cmd_wr   = reg_wr && (reg_addr == AW'(RA_CMDW));
  assign stat_clr = wr_stat && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      soft_rst <= 1'b0;
      done     <= 1'b0;
      t_lo     <= TW'(1);
      t_hi     <= TW'(1);
      addr_lo  <= '0;
      addr_hi  <= '0;
      aux_cmd  <= '0;
    end else begin
      if (wr_ctrl) en <= reg_wdata[0];
      // soft reset lasts exactly one cycle, then clears itself
      soft_rst <= wr_ctrl && reg_wdata[1] && !soft_rst;
      if (seq_done)      done <= 1'b1;
      else if (stat_clr) done <= 1'b0;
      if (wr_time) begin
        t_lo <= reg_wdata[TW-1:0];
        t_hi <= reg_wdata[2*TW-1:TW];
      end
      if (wr_alo) addr_lo <= reg_wdata;
      if (wr_ahi) addr_hi <= reg_wdata[7:0];
      if (wr_aux) aux_cmd <= reg_wdata;
    end
  end

  assign addr40   = {addr_hi, addr_lo};
  assign aux_byte = aux_cmd[7:0];

  always_comb begin
    case (reg_addr)
      AW'(RA_CTRL): reg_rdata = {30'd0, soft_rst, en};
      AW'(RA_STAT): reg_rdata = {30'd0, done, busy};
      AW'(RA_TIME): reg_rdata = {{(32-2*TW){1'b0}}, t_hi, t_lo};
      AW'(RA_ALO):  reg_rdata = addr_lo;
      AW'(RA_AHI):  reg_rdata = {24'd0, addr_hi};
      AW'(RA_AUX):  reg_rdata = aux_cmd;
      default:      reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int TW         = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start_req,
  input  phase_req_t    req_in,
  input  logic [7:0]    c1_in,
  input  logic [2:0]    acyc_field,
  input  logic [7:0]    aux_byte,
  input  logic [39:0]   addr40,
  input  logic [TW-1:0] t_lo,
  input  logic [TW-1:0] t_hi,
  input  logic          rb_ready,
  output logic          busy,
  output logic          seq_start,
  output logic          seq_done,
  output logic          in_wait,
  output logic [7:0]    io,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          ce_n
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int CW = (TW > SW) ? TW : SW;
  localparam logic [CW-1:0] ONE = CW'(1);

  seq_state_t    state, nxt_state;
  phase_req_t    req;
  logic [7:0]    c1_byte, c2_byte;
  logic [39:0]   addr_q;
  logic [2:0]    ncyc, aidx, nxt_aidx;
  logic [TW-1:0] lo_w, hi_w;
  logic          we_low, nxt_we_low;
  logic [CW-1:0] tcnt, nxt_tcnt;
  logic          strobing, byte_last;

  assign busy      = (state != S_IDLE);
  assign seq_start = start_req && !busy && !abort;
  assign strobing  = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2);
  assign byte_last = (state != S_ADDR) || (aidx == ncyc - 3'd1);
  assign in_wait   = (state == S_WAIT);

  always_comb begin
    nxt_state  = state;
    nxt_we_low = we_low;
    nxt_tcnt   = tcnt;
    nxt_aidx   = aidx;
    if (abort) begin
      nxt_state  = S_IDLE;
      nxt_we_low = 1'b0;
      nxt_tcnt   = '0;
      nxt_aidx   = '0;
    end else begin
      case (state)
        S_IDLE: if (seq_start) begin
          nxt_state  = phase_after(S_IDLE, req_in);
          nxt_we_low = 1'b1;
          nxt_tcnt   = '0;
          nxt_aidx   = '0;
        end
        S_SETTLE: if (tcnt == CW'(SETTLE_CYC - 1)) begin
          nxt_state = S_WAIT;
          nxt_tcnt  = '0;
        end else nxt_tcnt = tcnt + ONE;
        S_WAIT: if (rb_ready) nxt_state = S_IDLE;
        default: begin
          if (we_low) begin
            if (tcnt == CW'(lo_w) - ONE) begin
              nxt_we_low = 1'b0;
              nxt_tcnt   = '0;
            end else nxt_tcnt = tcnt + ONE;
          end else if (tcnt == CW'(hi_w) - ONE) begin
            nxt_we_low = 1'b1;
            nxt_tcnt   = '0;
            if (!byte_last) nxt_aidx = aidx + 3'd1;
            else            nxt_state = phase_after(state, req);
          end else nxt_tcnt = tcnt + ONE;
        end
      endcase
    end
  end

  assign seq_done = !abort && (busy || seq_start) && (nxt_state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      we_low  <= 1'b0;
      tcnt    <= '0;
      aidx    <= '0;
      req     <= '0;
      c1_byte <= '0;
      c2_byte <= '0;
      addr_q  <= '0;
      ncyc    <= 3'd1;
      lo_w    <= TW'(1);
      hi_w    <= TW'(1);
    end else begin
      state  <= nxt_state;
      we_low <= nxt_we_low;
      tcnt   <= nxt_tcnt;
      aidx   <= nxt_aidx;
      if (seq_start) begin
        req     <= req_in;
        c1_byte <= c1_in;
        c2_byte <= aux_byte;
        addr_q  <= addr40;
        ncyc    <= addr_cycles(acyc_field);
        lo_w    <= (t_lo == '0) ? TW'(1) : t_lo;
        hi_w    <= (t_hi == '0) ? TW'(1) : t_hi;
      end
    end
  end

  always_comb begin
    case (state)
      S_CMD1:  io = c1_byte;
      S_ADDR:  io = addr_q[{aidx, 3'b000} +: 8];
      S_CMD2:  io = c2_byte;
      default: io = 8'h00;
    endcase
  end

  assign cle  = (state == S_CMD1) || (state == S_CMD2);
  assign ale  = (state == S_ADDR);
  assign we_n = !(strobing && we_low);
  assign ce_n = !busy;
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int AW         = 3,
  parameter int TW         = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [7:0]    nand_io,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_ce_n,
  input  logic          nand_rb_n
);
  logic          busy, done, en, soft_rst, cmd_wr, stat_clr;
  logic          seq_start, seq_done, in_wait, rb_ready;
  logic [TW-1:0] t_lo, t_hi;
  logic [39:0]   addr40;
  logic [7:0]    aux_byte;
  phase_req_t    req_in;

  assign req_in = '{c1: reg_wdata[CW_C1_BIT], ad: reg_wdata[CW_ADDR_BIT],
                    c2: reg_wdata[CW_C2_BIT], wt: reg_wdata[CW_WAIT_BIT]};

  nand_seq_regs #(.AW(AW), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .seq_done(seq_done), .en(en), .soft_rst(soft_rst), .cmd_wr(cmd_wr),
    .stat_clr(stat_clr), .done(done), .t_lo(t_lo), .t_hi(t_hi),
    .addr40(addr40), .aux_byte(aux_byte)
  );

  nand_seq_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d_async(nand_rb_n), .q_sync(rb_ready)
  );

  nand_seq_fsm #(.TW(TW), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start_req(cmd_wr && en),
    .req_in(req_in), .c1_in(reg_wdata[7:0]), .acyc_field(reg_wdata[18:16]),
    .aux_byte(aux_byte), .addr40(addr40), .t_lo(t_lo), .t_hi(t_hi),
    .rb_ready(rb_ready), .busy(busy), .seq_start(seq_start),
    .seq_done(seq_done), .in_wait(in_wait), .io(nand_io), .cle(nand_cle),
    .ale(nand_ale), .we_n(nand_we_n), .ce_n(nand_ce_n)
  );
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       ce_n,
  input logic       busy,
  input logic       done,
  input logic       seq_start,
  input logic       soft_rst,
  input logic       stat_clr,
  input logic       in_wait,
  input logic       rb_ready
);
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R2

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R7

  AST_CE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> busy); // R7

  AST_BYTE_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n) && !$past(soft_rst)) |-> ($stable(io) && $stable(cle) && $stable(ale))); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stat_clr) |=> done); // R6

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> !busy); // R8

  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!soft_rst && !busy)); // R10

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !rb_ready && !soft_rst) |=> busy); // R5
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io(nand_io), .cle(nand_cle), .ale(nand_ale),
  .we_n(nand_we_n), .ce_n(nand_ce_n), .busy(busy), .done(done),
  .seq_start(seq_start), .soft_rst(soft_rst), .stat_clr(stat_clr),
  .in_wait(in_wait), .rb_ready(rb_ready)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  localparam int SETTLE = 4;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TIME = 3'd2,
                         A_ALO = 3'd3, A_AHI = 3'd4, A_AUX = 3'd5, A_CMDW = 3'd6;
  localparam logic [31:0] B_C1 = 32'h0040_0000, B_ADDR = 32'h0008_0000,
                          B_WAIT = 32'h0080_0000, B_C2 = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [7:0]  nand_io;
  logic        nand_cle, nand_ale, nand_we_n, nand_ce_n;
  logic        nand_rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nand_cmd_seq u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nand_io(nand_io),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_ce_n(nand_ce_n), .nand_rb_n(nand_rb_n)
  );

  // strobe monitor: records each byte when WE# returns high
  logic [7:0] cap_b [64];
  logic [1:0] cap_k [64];
  int         cap_l [64];
  int         ncap = 0;
  int         low_run = 0;
  logic       prev_we = 1'b1;
  logic [7:0] cur_b = 8'h00;
  logic [1:0] cur_k = 2'b00;

  always @(negedge clk) begin
    if (!nand_we_n) begin
      low_run = low_run + 1;
      cur_b   = nand_io;
      cur_k   = {nand_cle, nand_ale};
    end else if (!prev_we) begin
      cap_b[ncap & 63] = cur_b;
      cap_k[ncap & 63] = cur_k;
      cap_l[ncap & 63] = low_run;
      ncap    = ncap + 1;
      low_run = 0;
    end
    prev_we = nand_we_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // number of negedges after the first post-accept negedge until done shows
  task automatic wait_done(input int limit, output int j);
    logic [31:0] s;
    j = 0;
    rd(A_STAT, s);
    while (!s[1] && j < limit) begin
      @(negedge clk);
      j++;
      rd(A_STAT, s);
    end
  endtask

  function automatic int exp_len(int n, int lo, int hi, bit wt);
    int l = (lo == 0) ? 1 : lo;
    int h = (hi == 0) ? 1 : hi;
    return n * (l + h) + (wt ? SETTLE + 1 : 0);
  endfunction

  task automatic chk_byte(input int idx, input logic [7:0] b, input logic [1:0] k,
                          input int lo, input string req);
    chk(cap_b[idx & 63] == b, req, cap_b[idx & 63], b);
    chk(cap_k[idx & 63] == k, req, cap_k[idx & 63], k);
    chk(cap_l[idx & 63] == lo, req, cap_l[idx & 63], lo);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(A_STAT, s);
    chk(s == 0, "R12 status", s, 0);
    chk({nand_we_n, nand_ce_n, nand_cle, nand_ale} == 4'b1100, "R12 pins",
        {nand_we_n, nand_ce_n, nand_cle, nand_ale}, 4'b1100);
  endtask

  task automatic t_full_read;
    int n0, j;
    wr(A_CTRL, 32'h1);
    wr(A_TIME, 32'h32);
    wr(A_ALO, 32'hA1B2_0000);
    wr(A_AHI, 32'hFFFF_FF5C);
    wr(A_AUX, 32'h00E0_0530);
    n0 = ncap;
    wr(A_CMDW, B_C1 | B_ADDR | B_C2 | 32'h0004_0000);
    wait_done(200, j);
    idle(2);
    chk(ncap - n0 == 7, "R4 byte count", ncap - n0, 7);
    chk_byte(n0,     8'h00, 2'b10, 2, "R1 first cmd");
    chk_byte(n0 + 1, 8'h00, 2'b01, 2, "R2 addr0");
    chk_byte(n0 + 2, 8'h00, 2'b01, 2, "R2 addr1");
    chk_byte(n0 + 3, 8'hB2, 2'b01, 2, "R2 addr2");
    chk_byte(n0 + 4, 8'hA1, 2'b01, 2, "R2 addr3");
    chk_byte(n0 + 5, 8'h5C, 2'b01, 2, "R2 addr4 high reg");
    chk_byte(n0 + 6, 8'h30, 2'b10, 2, "R3 second cmd");
    chk(j == exp_len(7, 2, 3, 0), "R4 duration", j, exp_len(7, 2, 3, 0));
    wr(A_STAT, 32'h2);
  endtask

  task automatic t_wait_busy;
    logic [31:0] s;
    int n0;
    nand_rb_n = 1'b0;
    n0 = ncap;
    wr(A_CMDW, B_C1 | B_WAIT | 32'hFF);
    idle(40);
    rd(A_STAT, s);
    chk(s == 32'h1, "R5 R7 held by busy", s, 1);
    chk(nand_ce_n == 1'b0, "R7 ce during wait", nand_ce_n, 0);
    @(negedge clk); nand_rb_n = 1'b1;
    @(negedge clk); rd(A_STAT, s);
    chk(s[1] == 1'b0, "R5 sync edge1", s[1], 0);
    @(negedge clk); rd(A_STAT, s);
    chk(s[1] == 1'b0, "R5 sync edge2", s[1], 0);
    @(negedge clk); rd(A_STAT, s);
    chk(s == 32'h2, "R5 done edge3", s, 2);
    chk(ncap - n0 == 1 && cap_b[n0 & 63] == 8'hFF, "R1 wait cmd byte", cap_b[n0 & 63], 8'hFF);
    wr(A_STAT, 32'h2);
  endtask

  task automatic t_wait_ready_floor;
    int n0, j;
    wr(A_TIME, 32'h00);
    n0 = ncap;
    wr(A_CMDW, B_C1 | B_WAIT | 32'h70);
    wait_done(200, j);
    idle(2);
    chk(j == exp_len(1, 0, 0, 1), "R4 R5 zero widths and settle", j, exp_len(1, 0, 0, 1));
    chk_byte(n0, 8'h70, 2'b10, 1, "R4 zero low width");
  endtask

  task automatic t_sticky;
    logic [31:0] s;
    wr(A_STAT, 32'h0);
    idle(2);
    rd(A_STAT, s);
    chk(s == 32'h2, "R6 write 0 keeps done", s, 2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, s);
    chk(s == 32'h0, "R6 write 1 clears", s, 0);
  endtask

  task automatic t_no_phase;
    int n0, j;
    n0 = ncap;
    wr(A_CMDW, 32'h0000_00AA);
    wait_done(50, j);
    idle(3);
    chk(j == 0, "R9 immediate done", j, 0);
    chk(ncap == n0, "R9 no strobe", ncap - n0, 0);
    wr(A_STAT, 32'h2);
  endtask

  task automatic t_ignore;
    logic [31:0] s;
    int n0, j;
    wr(A_TIME, 32'h22);
    nand_rb_n = 1'b0;
    n0 = ncap;
    wr(A_CMDW, B_C1 | B_WAIT | 32'h90);
    idle(15);
    wr(A_CMDW, B_C1 | 32'h11);
    idle(5);
    nand_rb_n = 1'b1;
    wait_done(100, j);
    idle(20);
    rd(A_STAT, s);
    chk(s == 32'h2, "R8 no second run", s, 2);
    chk(ncap - n0 == 1, "R8 busy write ignored", ncap - n0, 1);
    chk(cap_b[n0 & 63] == 8'h90, "R8 first byte kept", cap_b[n0 & 63], 8'h90);
    wr(A_STAT, 32'h2);
    wr(A_CTRL, 32'h0);
    n0 = ncap;
    wr(A_CMDW, B_C1 | 32'h22);
    idle(10);
    rd(A_STAT, s);
    chk(s == 32'h0, "R8 disabled status", s, 0);
    chk(ncap == n0, "R8 disabled no strobe", ncap - n0, 0);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic t_addr_count_type;
    int n0, j;
    n0 = ncap;
    wr(A_ALO, 32'h4433_2211);
    wr(A_AHI, 32'h55);
    wr(A_CMDW, B_ADDR | 32'h0007_0000);
    wait_done(200, j);
    idle(2);
    chk(ncap - n0 == 5, "R2 field 7 gives five", ncap - n0, 5);
    chk_byte(n0 + 4, 8'h55, 2'b01, 2, "R2 fifth byte");
    wr(A_STAT, 32'h2);
    n0 = ncap;
    wr(A_CMDW, 32'h8000_0000 | B_C1 | B_ADDR | 32'h0001_0060);
    wait_done(200, j);
    idle(2);
    chk(ncap - n0 == 3, "R2 R11 two addr cycles", ncap - n0, 3);
    chk_byte(n0,     8'h60, 2'b10, 2, "R11 typed cmd");
    chk_byte(n0 + 2, 8'h22, 2'b01, 2, "R2 second addr");
    chk(j == exp_len(3, 2, 2, 0), "R11 duration", j, exp_len(3, 2, 2, 0));
    wr(A_STAT, 32'h2);
  endtask

  task automatic t_soft_reset;
    logic [31:0] s;
    nand_rb_n = 1'b0;
    wr(A_CMDW, B_C1 | B_WAIT | 32'hEE);
    idle(20);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, s);
    chk(s == 32'h3, "R10 bit set", s, 3);
    @(negedge clk);
    rd(A_CTRL, s);
    chk(s == 32'h1, "R10 bit self clears", s, 1);
    rd(A_STAT, s);
    chk(s == 32'h0, "R10 idle no done", s, 0);
    chk(nand_ce_n == 1'b1, "R10 ce released", nand_ce_n, 1);
    nand_rb_n = 1'b1;
    idle(6);
    rd(A_STAT, s);
    chk(s == 32'h0, "R10 stays idle", s, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_full_read();
    t_wait_busy();
    t_wait_ready_floor();
    t_sticky();
    t_no_phase();
    t_ignore();
    t_addr_count_type();
    t_soft_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule